// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate datapath. Each clock it can take two signed 16-bit operands and an operation code. It forms their 32-bit signed product and folds the product into a 40-bit accumulator. The accumulator's eight guard bits above the product width absorb long runs of accumulation before overflow becomes possible.

The operation code selects one of four actions: add the product, subtract the product, replace the accumulator with the product, or clear the accumulator. A saturation enable decides how overflow is handled. When it is set, a result that falls outside the 40-bit signed range is clamped to the nearest limit. When it is clear, the result wraps. A sticky flag records any overflow until the next load or clear.

The accumulator is presented as two 32-bit words, as a register pair would hold it. The low word carries bits 31..0. The high word carries bits 39..32 in its low byte and copies of bit 39 above that.

Top module: `sat_mac`

## Requirements
- R1: With `op_code` = 0 (add), the accumulator becomes its previous value plus the signed product `op_a` × `op_b`.
- R2: With `op_code` = 1 (subtract), the accumulator becomes its previous value minus the signed product.
- R3: With `op_code` = 2 (load), the accumulator is replaced by the signed product and the sticky overflow flag is cleared.
- R4: With `op_code` = 3 (clear), the accumulator and the sticky overflow flag both become zero, and the operands are ignored.
- R5: A new operation is accepted on every clock edge where `in_valid` is high. Its effect on the accumulator appears after the second rising edge from that edge. `acc_valid` is high exactly two cycles after `in_valid` was high.
- R6: With `sat_en` high, an add or subtract whose exact result exceeds 2^39−1 leaves the accumulator at 2^39−1 (0x7FFFFFFFFF).
- R7: With `sat_en` high, an add or subtract whose exact result is below −2^39 leaves the accumulator at −2^39 (0x8000000000). Reaching −2^39 exactly is not an overflow.
- R8: With `sat_en` low, the accumulator wraps modulo 2^40.
- R9: `acc_ovf` is set by any add or subtract whose exact result lies outside the 40-bit signed range, whether `sat_en` is high or low. It stays set until a load or clear.
- R10: `acc_lo` equals accumulator bits 31..0. `acc_hi` equals bits 39..32 in its bits 7..0, with bit 39 copied into bits 31..8.
- R11: Cycles with `in_valid` low leave the accumulator and `acc_ovf` unchanged, whatever the other inputs are.
- R12: After reset, the accumulator is zero and `acc_ovf` and `acc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| op_code | input | 2 | 0 add, 1 subtract, 2 load, 3 clear |
| sat_en | input | 1 | Clamp on overflow when high, wrap when low |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| acc_hi | output | 32 | Accumulator bits 39..32, sign-extended |
| acc_ovf | output | 1 | Sticky overflow flag |
| acc_valid | output | 1 | Accumulator updated by an operation this cycle |

## Verification
The hardest states to reach from the ports are the two ends of the 40-bit range. The largest product is 2^30, so at least 512 operations are needed to reach either limit. The bench loads the product (−32768)·(−32768) and streams hundreds of back-to-back adds to just below +2^39. It then steps once more with saturation on and once more with it off, to tell clamping apart from wrapping. It also subtracts the same product 512 times from zero to land exactly on −2^39 without overflow, and then once more to underflow.

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [1:0]        op_code,
  input  logic              sat_en,
  output logic [WORD_W-1:0] acc_lo,
  output logic [WORD_W-1:0] acc_hi,
  output logic              acc_ovf,
  output logic              acc_valid
);

  localparam int PROD_W = 2 * OP_W;
  localparam int SUM_W  = ACC_W + 1;
  localparam int HI_EXT = 2 * WORD_W - ACC_W;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_LOAD = 2'd2, OP_CLR = 2'd3} op_e;

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] prod_q;
  op_e                      op_q;
  logic                     sat_q;
  logic                     v1_q;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] prod_ext, acc_ext, sum;
  logic             over;
  logic [ACC_W-1:0] fixed;
  logic [ACC_W-1:0] acc_d;

  assign product = $signed(op_a) * $signed(op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      op_q   <= OP_ADD;
      sat_q  <= 1'b0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        prod_q <= product;
        op_q   <= op_e'(op_code);
        sat_q  <= sat_en;
      end
    end
  end

  assign prod_ext = {{(SUM_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
  assign acc_ext  = {acc_q[ACC_W-1], acc_q};
  assign sum      = (op_q == OP_SUB) ? acc_ext - prod_ext : acc_ext + prod_ext;
  assign over     = sum[ACC_W] ^ sum[ACC_W-1];
  assign fixed    = !over ? sum[ACC_W-1:0] : (sum[ACC_W] ? ACC_MIN : ACC_MAX);

  always_comb begin
    unique case (op_q)
      OP_LOAD: acc_d = prod_ext[ACC_W-1:0];
      OP_CLR:  acc_d = '0;
      default: acc_d = sat_q ? fixed : sum[ACC_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      acc_ovf   <= 1'b0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= v1_q;
      if (v1_q) begin
        acc_q <= acc_d;
        if (op_q == OP_LOAD || op_q == OP_CLR) acc_ovf <= 1'b0;
        else if (over)                         acc_ovf <= 1'b1;
      end
    end
  end

  assign acc_lo = acc_q[WORD_W-1:0];
  assign acc_hi = {{HI_EXT{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:WORD_W]};

endmodule

module sat_mac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op_code,
  input logic [31:0] acc_lo,
  input logic [31:0] acc_hi,
  input logic        acc_ovf,
  input logic        acc_valid
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  wire warm = (age == 2'd3);

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> acc_valid == $past(in_valid, 2));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(in_valid, 2)) |-> ($stable(acc_lo) && $stable(acc_hi) && $stable(acc_ovf)));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(op_code, 2) == 2'd3) |-> (acc_lo == '0 && acc_hi == '0 && !acc_ovf));

  // R3
  load_unflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(op_code, 2) == 2'd2) |-> !acc_ovf);

  // R9
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $fell(acc_ovf)) |-> ($past(in_valid, 2) && $past(op_code[1], 2)));

  // R9
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(acc_ovf)) |-> ($past(in_valid, 2) && !$past(op_code[1], 2)));
endmodule

bind sat_mac sat_mac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .acc_lo(acc_lo), .acc_hi(acc_hi), .acc_ovf(acc_ovf), .acc_valid(acc_valid)
);

// File: tb/sat_mac_tb.sv
module sat_mac_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0]  op_code = '0;
  logic        sat_en = 1'b0;
  logic [31:0] acc_lo, acc_hi;
  logic        acc_ovf, acc_valid;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  sat_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_code(op_code), .sat_en(sat_en), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .acc_ovf(acc_ovf), .acc_valid(acc_valid)
  );

  // {a, b, op_code, sat_en, expected 40-bit accumulator}
  localparam logic [74:0] TBL [NV] = '{
    {16'h0003, 16'h0004, 2'd2, 1'b1, 40'h00_0000_000C},
    {16'hFFFB, 16'h0006, 2'd0, 1'b1, 40'hFF_FFFF_FFEE},
    {16'h0007, 16'hFFFE, 2'd1, 1'b1, 40'hFF_FFFF_FFFC},
    {16'h0064, 16'h0064, 2'd0, 1'b1, 40'h00_0000_270C},
    {16'h1234, 16'h5678, 2'd3, 1'b1, 40'h00_0000_0000},
    {16'h8000, 16'h8000, 2'd2, 1'b1, 40'h00_4000_0000},
    {16'h8000, 16'h8000, 2'd0, 1'b1, 40'h00_8000_0000},
    {16'h03E8, 16'h03E8, 2'd1, 1'b1, 40'h00_7FF0_BDC0},
    {16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 40'h00_7FF0_BDC1},
    {16'hFFFE, 16'h0003, 2'd2, 1'b1, 40'hFF_FFFF_FFFA}
  };

  task automatic chk(input string tag, input logic [39:0] e, input logic eovf);
    logic [31:0] ehi;
    ehi = {{24{e[39]}}, e[39:32]};
    checks++;
    if (acc_lo !== e[31:0] || acc_hi !== ehi || acc_ovf !== eovf) begin
      fails++;
      $display("FAIL %s: got hi=%h lo=%h ovf=%b, expected hi=%h lo=%h ovf=%b",
               tag, acc_hi, acc_lo, acc_ovf, ehi, e[31:0], eovf);
    end
  endtask

  task automatic chk_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b, expected %b", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic [1:0] c, input logic s);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; op_code = c; sat_en = s;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    chk("R12 reset", 40'h0, 1'b0);
    chk_bit("R12 valid in reset", acc_valid, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R12 after release", 40'h0, 1'b0);

    // R1 R2 R3 R4 R5 R10: back-to-back stream, each result two cycles later
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R1 R2 R3 R4 R10 vector %0d", i - 2), TBL[i-2][39:0], 1'b0);
        chk_bit("R5 valid streaming", acc_valid, 1'b1);
      end
      if (i < NV) begin
        in_valid = 1'b1;
        op_a = TBL[i][74:59]; op_b = TBL[i][58:43];
        op_code = TBL[i][42:41]; sat_en = TBL[i][40];
      end else in_valid = 1'b0;
    end
    idle(2);
    chk_bit("R5 valid drops", acc_valid, 1'b0);

    // R11: inputs toggle while in_valid is low
    @(negedge clk); in_valid = 1'b0; op_a = 16'h7FFF; op_b = 16'h7FFF; op_code = 2'd3;
    @(negedge clk); op_code = 2'd2;
    idle(3);
    chk("R11 idle ignored", 40'hFF_FFFF_FFFA, 1'b0);

    // R6 R9: climb to just below +2^39, then saturate
    issue(16'h8000, 16'h8000, 2'd2, 1'b1);
    for (int k = 0; k < 510; k++) issue(16'h8000, 16'h8000, 2'd0, 1'b1);
    idle(2);
    chk("R6 below limit", 40'h7F_C000_0000, 1'b0);
    issue(16'h8000, 16'h8000, 2'd0, 1'b1);
    idle(2);
    chk("R6 clamp max", 40'h7F_FFFF_FFFF, 1'b1);
    issue(16'h8000, 16'h8000, 2'd0, 1'b1);
    idle(2);
    chk("R6 stays at max", 40'h7F_FFFF_FFFF, 1'b1);
    issue(16'h0001, 16'h0001, 2'd1, 1'b1);
    idle(2);
    chk("R9 sticky holds", 40'h7F_FFFF_FFFE, 1'b1);
    issue(16'h0001, 16'h0001, 2'd2, 1'b1);
    idle(2);
    chk("R3 load clears flag", 40'h00_0000_0001, 1'b0);

    // R8 R9: same climb with saturation off wraps
    issue(16'h8000, 16'h8000, 2'd2, 1'b0);
    for (int k = 0; k < 511; k++) issue(16'h8000, 16'h8000, 2'd0, 1'b0);
    idle(2);
    chk("R8 wrap to min", 40'h80_0000_0000, 1'b1);
    issue(16'h0000, 16'h0000, 2'd3, 1'b0);
    idle(2);
    chk("R4 clear", 40'h0, 1'b0);

    // R7: descend to exactly -2^39, then underflow
    for (int k = 0; k < 512; k++) issue(16'h8000, 16'h8000, 2'd1, 1'b1);
    idle(2);
    chk("R7 exact min no ovf", 40'h80_0000_0000, 1'b0);
    issue(16'h8000, 16'h8000, 2'd1, 1'b1);
    idle(2);
    chk("R7 clamp min", 40'h80_0000_0000, 1'b1);
    issue(16'h1111, 16'h2222, 2'd3, 1'b1);
    idle(2);
    chk("R4 clear after ovf", 40'h0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule